// File: doc/BRIEF.md
# Multiple-Sampling Ramp Noise Reducer

This block takes a stream of nondestructive digital reads of pixel integration ramps and returns one noise-reduced signal estimate per pixel ramp. Each input beat carries a sample value, a pixel index, a flag marking the first read after the pixel reset, and a flag marking the last read of the ramp. Reads of different pixels may be interleaved freely. Running sums for every pixel live in an on-chip accumulator array, so a result is available as soon as the closing read arrives.

Two estimators are selectable. In group-difference mode, the block subtracts the mean of the first N reads from the mean of the last N reads, with N a power of two. In slope mode, it fits a straight line to all M reads by least squares and reports the slope. The slope mode keeps only the running sums of y and k·y. The sums over k and k² depend only on M, so they are generated from it in closed form. A multi-cycle sequential divider then forms the quotient. Both results carry `FRAC_W` fractional bits. N and M are set before a frame starts and stay fixed while it runs.

Top module: `ramp_noise_reducer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0.
- R2: Group-difference mode (`cfg_slope`=0). Let N = 2^`cfg_log2n`. Let A be the sum of the reads with index k in [0, N) and B the sum of the reads with index k in [M−N, M), where index 0 is the read marked `in_first`. The result is floor((B − A)·2^FRAC_W / N), taken as an arithmetic shift right.
- R3: Slope mode (`cfg_slope`=1). Let Sy = Σy, Sky = Σk·y, S1 = M(M−1)/2 and D = M²(M²−1)/12. The result is (M·Sky − S1·Sy)·2^FRAC_W / D, truncated toward zero.
- R4: A read with `in_first`=1 sets that pixel's read index to 0 and discards every sum gathered before it for that pixel.
- R5: Each pixel keeps its own sums. Reads of several pixels may be interleaved, and results for different pixels may close on consecutive cycles in group-difference mode. Every result carries its pixel index on `out_pixel`.
- R6: Reads after the M-th read of a ramp do not affect the result. A ramp that ends after more than M reads is treated as complete.
- R7: A ramp that ends after fewer than M reads yields a result with `out_incomplete`=1 and `out_value`=0. This result appears in the cycle after the closing read.
- R8: A configuration is invalid when M < 2, or when group-difference mode is selected with 2N > M. An invalid configuration makes every ramp end yield `out_err`=1, `out_incomplete`=0 and `out_value`=0, in the cycle after the closing read.
- R9: A complete group-difference result appears exactly one cycle after the closing read. A complete slope result appears only after the divider finishes, later than one cycle. `out_valid` pulses for exactly one cycle per ramp end.
- R10: Reads that do not close a ramp may arrive while a slope division is in progress, and they are accumulated normally. A ramp end must not arrive while a division is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slope | input | 1 | 1 = least-squares slope, 0 = group difference |
| cfg_log2n | input | LOGN_W | log2 of the group size N |
| cfg_m | input | CNT_W | Reads per complete ramp, M |
| in_valid | input | 1 | A read is present |
| in_pixel | input | PIX_W | Pixel index of the read |
| in_sample | input | DATA_W | Unsigned read value |
| in_first | input | 1 | First read after the pixel reset |
| in_last | input | 1 | Closing read of the ramp |
| out_valid | output | 1 | One-cycle result strobe |
| out_pixel | output | PIX_W | Pixel the result belongs to |
| out_value | output | OUT_W | Signed result with FRAC_W fraction bits |
| out_incomplete | output | 1 | Ramp ended before M reads |
| out_err | output | 1 | Configuration invalid |

## Verification
The assertions check on every cycle that flagged results carry a zero value, that the two flags never appear together, and that a ramp end is never presented while the divider is busy or delivering. They also check that the divider only starts when idle and only reports completion straight out of a busy cycle. The arithmetic itself is shown only by the bench's scenarios. These cover ascending and descending ramps with odd differences that exercise floor versus truncation, the 2N = M boundary, the largest M, interleaved pixels, restarts in mid-ramp, surplus reads, and reads that arrive during a division. Each result is checked against values computed from the stored reads.

// File: rtl/rnr_pkg.sv
package rnr_pkg;

    typedef enum logic {
        FIT_GROUP = 1'b0,
        FIT_SLOPE = 1'b1
    } fit_mode_e;

    // A configuration that cannot produce a meaningful estimate.
    function automatic logic cfg_invalid(input int unsigned m,
                                         input int unsigned log2n,
                                         input fit_mode_e   mode);
        int unsigned n;
        n = 32'd1 << log2n;
        return (m < 2) || ((mode == FIT_GROUP) && ((2 * n) > m));
    endfunction

endpackage

// File: rtl/rnr_acc_mem.sv
module rnr_acc_mem #(
    parameter int NUM_PIX = 4,
    parameter int ENT_W   = 8,
    localparam int ADDR_W = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ENT_W-1:0]  rd_data
);

    logic [ENT_W-1:0] row_arr [NUM_PIX];

    for (genvar g = 0; g < NUM_PIX; g++) begin : g_row
        logic [ENT_W-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                row_q <= wr_data;
            end
        end
        assign row_arr[g] = row_q;
    end

    assign rd_data = row_arr[rd_addr];

endmodule

// File: rtl/rnr_fit_coef.sv
module rnr_fit_coef #(
    parameter int CNT_W = 6,
    localparam int S1_W  = 2 * CNT_W,
    localparam int DEN_W = 4 * CNT_W
) (
    input  logic [CNT_W-1:0] m,
    output logic [S1_W-1:0]  s1,
    output logic [DEN_W-1:0] den
);

    logic [S1_W-1:0]  m_ext;
    logic [S1_W-1:0]  m_m1;
    logic [DEN_W-1:0] m_sq;
    logic [DEN_W-1:0] m_sq_m1;

    always_comb begin
        m_ext   = S1_W'(m);
        m_m1    = (m == '0) ? '0 : (m_ext - S1_W'(1));
        s1      = (m_ext * m_m1) >> 1;
        m_sq    = DEN_W'(m) * DEN_W'(m);
        m_sq_m1 = (m_sq == '0) ? '0 : (m_sq - DEN_W'(1));
        den     = (m_sq * m_sq_m1) / DEN_W'(12);
    end

endmodule

// File: rtl/rnr_slope_div.sv
module rnr_slope_div #(
    parameter int NUM_W = 35,
    parameter int DEN_W = 24,
    parameter int OUT_W = 18,
    parameter int TAG_W = 2,
    localparam int MAG_W  = NUM_W - 1,
    localparam int STEP_W = $clog2(MAG_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [NUM_W-1:0] num,
    input  logic [DEN_W-1:0]        den,
    input  logic [TAG_W-1:0]        tag_in,
    output logic                    busy,
    output logic                    done,
    output logic signed [OUT_W-1:0] quo,
    output logic [TAG_W-1:0]        tag_out
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              neg;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  rem;
        logic [DEN_W-1:0]  den;
        logic [MAG_W-1:0]  quo;
        logic [TAG_W-1:0]  tag;
    } div_t;

    div_t st_d, st_q;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = {st_q.rem, st_q.quo[MAG_W-1]};
        fits      = trial >= {1'b0, st_q.den};
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.neg  = num[NUM_W-1];
            st_d.quo  = MAG_W'(num[NUM_W-1] ? -num : num);
            st_d.rem  = '0;
            st_d.den  = den;
            st_d.step = '0;
            st_d.tag  = tag_in;
        end else if (st_q.busy) begin
            st_d.rem  = fits ? DEN_W'(trial - {1'b0, st_q.den}) : DEN_W'(trial);
            st_d.quo  = {st_q.quo[MAG_W-2:0], fits};
            st_d.step = st_q.step + STEP_W'(1);
            if (st_q.step == STEP_W'(MAG_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign tag_out = st_q.tag;
    assign quo     = OUT_W'(st_q.neg ? -$signed({1'b0, st_q.quo}) : $signed({1'b0, st_q.quo}));

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !st_q.busy); // R10

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy)); // R9

endmodule

// File: rtl/ramp_noise_reducer.sv
module ramp_noise_reducer #(
    parameter int DATA_W  = 12,
    parameter int NUM_PIX = 4,
    parameter int MAX_M   = 32,
    parameter int FRAC_W  = 4,
    localparam int PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
    localparam int CNT_W  = $clog2(MAX_M + 1),
    localparam int LOGN_W = $clog2(CNT_W),
    localparam int OUT_W  = DATA_W + FRAC_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_slope,
    input  logic [LOGN_W-1:0] cfg_log2n,
    input  logic [CNT_W-1:0]  cfg_m,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    output logic [OUT_W-1:0]  out_value,
    output logic              out_incomplete,
    output logic              out_err
);

    import rnr_pkg::*;

    localparam int SUM_W = DATA_W + CNT_W;
    localparam int KY_W  = DATA_W + 2 * CNT_W;
    localparam int NUM_W = KY_W + CNT_W + FRAC_W + 1;
    localparam int DEN_W = 4 * CNT_W;
    localparam int S1_W  = 2 * CNT_W;
    localparam int GRP_W = SUM_W + 1 + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sa;
        logic [SUM_W-1:0] sb;
        logic [SUM_W-1:0] sy;
        logic [KY_W-1:0]  sky;
    } acc_t;

    localparam int ENT_W = $bits(acc_t);

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
        logic [OUT_W-1:0] val;
        logic             inc;
        logic             err;
    } res_t;

    fit_mode_e mode;
    assign mode = fit_mode_e'(cfg_slope);

    // Accumulator array
    logic [ENT_W-1:0] rd_raw;
    acc_t             rd_ent, base, nxt;

    rnr_acc_mem #(.NUM_PIX(NUM_PIX), .ENT_W(ENT_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_addr (in_pixel),
        .wr_data (nxt),
        .rd_addr (in_pixel),
        .rd_data (rd_raw)
    );
    assign rd_ent = acc_t'(rd_raw);

    // Closed-form index sums for the configured M
    logic [S1_W-1:0]  s1;
    logic [DEN_W-1:0] den;

    rnr_fit_coef #(.CNT_W(CNT_W)) u_coef (
        .m   (cfg_m),
        .s1  (s1),
        .den (den)
    );

    // Slope divider
    logic                    div_start, div_busy, div_done;
    logic signed [NUM_W-1:0] div_num;
    logic signed [OUT_W-1:0] div_q;
    logic [PIX_W-1:0]        div_pix;

    rnr_slope_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .OUT_W(OUT_W), .TAG_W(PIX_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .num     (div_num),
        .den     (den),
        .tag_in  (in_pixel),
        .busy    (div_busy),
        .done    (div_done),
        .quo     (div_q),
        .tag_out (div_pix)
    );

    res_t res_d, res_q;

    logic [CNT_W-1:0]        k_idx;
    logic [CNT_W:0]          n_grp;
    logic                    take;
    logic                    cfg_bad;
    logic                    short_ramp;
    logic signed [SUM_W:0]   grp_diff;
    logic signed [GRP_W-1:0] grp_scaled;
    logic signed [GRP_W-1:0] grp_mean;
    logic [NUM_W-1:0]        prod_a, prod_b;

    always_comb begin
        // Per-pixel accumulation of the incoming read
        base  = in_first ? '0 : rd_ent;
        k_idx = in_first ? '0 : rd_ent.cnt;
        n_grp = (CNT_W + 1)'(1) << cfg_log2n;
        take  = k_idx < cfg_m;
        nxt   = base;
        if (take) begin
            nxt.cnt = k_idx + CNT_W'(1);
            if ({1'b0, k_idx} < n_grp) begin
                nxt.sa = base.sa + SUM_W'(in_sample);
            end
            if ((32'(k_idx) + 32'(n_grp)) >= 32'(cfg_m)) begin
                nxt.sb = base.sb + SUM_W'(in_sample);
            end
            nxt.sy  = base.sy + SUM_W'(in_sample);
            nxt.sky = base.sky + KY_W'(k_idx) * KY_W'(in_sample);
        end

        // Group-difference estimate
        grp_diff   = $signed({1'b0, nxt.sb}) - $signed({1'b0, nxt.sa});
        grp_scaled = GRP_W'(grp_diff) <<< FRAC_W;
        grp_mean   = grp_scaled >>> cfg_log2n;

        // Least-squares slope numerator
        prod_a  = NUM_W'(cfg_m) * NUM_W'(nxt.sky);
        prod_b  = NUM_W'(s1) * NUM_W'(nxt.sy);
        div_num = $signed(prod_a - prod_b) <<< FRAC_W;

        cfg_bad    = cfg_invalid(32'(cfg_m), 32'(cfg_log2n), mode);
        short_ramp = nxt.cnt < cfg_m;

        res_d     = res_q;
        res_d.vld = 1'b0;
        div_start = 1'b0;
        if (in_valid && in_last) begin
            if (cfg_bad || short_ramp || (mode == FIT_GROUP)) begin
                res_d.vld = 1'b1;
                res_d.pix = in_pixel;
                res_d.err = cfg_bad;
                res_d.inc = short_ramp && !cfg_bad;
                res_d.val = (cfg_bad || short_ramp) ? '0 : OUT_W'(grp_mean);
            end else begin
                div_start = 1'b1;
            end
        end
        if (div_done) begin
            res_d.vld = 1'b1;
            res_d.pix = div_pix;
            res_d.err = 1'b0;
            res_d.inc = 1'b0;
            res_d.val = div_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid      = res_q.vld;
    assign out_pixel      = res_q.pix;
    assign out_value      = res_q.val;
    assign out_incomplete = res_q.inc;
    assign out_err        = res_q.err;

    AST_SHORT_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_incomplete) |-> (out_value == '0)); // R7

    AST_ERR_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_value == '0)); // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_err && out_incomplete)); // R8

    AST_END_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> !(div_busy || div_done)); // R10

endmodule

// File: tb/sim_ramp_noise_reducer.sv
module sim_ramp_noise_reducer;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX  = 4;
    localparam int MAXM  = 32;
    localparam int FRAC  = 4;
    localparam int OUTW  = 18;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_slope;
    logic [2:0]       cfg_log2n;
    logic [5:0]       cfg_m;
    logic             in_valid;
    logic [1:0]       in_pixel;
    logic [11:0]      in_sample;
    logic             in_first;
    logic             in_last;
    logic             out_valid;
    logic [1:0]       out_pixel;
    logic [OUTW-1:0]  out_value;
    logic             out_incomplete;
    logic             out_err;

    ramp_noise_reducer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_slope(cfg_slope), .cfg_log2n(cfg_log2n),
        .cfg_m(cfg_m), .in_valid(in_valid), .in_pixel(in_pixel), .in_sample(in_sample),
        .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
        .out_pixel(out_pixel), .out_value(out_value), .out_incomplete(out_incomplete),
        .out_err(out_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int     pix;
        longint val;
        bit     inc;
        bit     err;
        longint when;
        bit     exact;
        string  tag;
    } exp_t;

    exp_t   sbq[$];
    longint smp [NPIX][MAXM];
    int     scnt [NPIX];
    int     cur_m;
    int     cur_l2n;
    bit     cur_slope;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t expect_for(input int pix, input string tag);
        exp_t   e;
        bit     bad;
        longint a, b, sy, sky, s1, dn, nm;
        int     n;
        n   = 1 << cur_l2n;
        bad = (cur_m < 2) || (!cur_slope && (2 * n > cur_m));
        e.pix  = pix;
        e.tag  = tag;
        e.err  = bad;
        e.inc  = !bad && (scnt[pix] < cur_m);
        e.val  = 0;
        e.when = cyc + 1;
        e.exact = bad || e.inc || !cur_slope;
        if (!bad && !e.inc) begin
            if (!cur_slope) begin
                a = 0; b = 0;
                for (int k = 0; k < n; k++) a += smp[pix][k];
                for (int k = cur_m - n; k < cur_m; k++) b += smp[pix][k];
                e.val = ((b - a) * (64'sd1 << FRAC)) >>> cur_l2n;
            end else begin
                sy = 0; sky = 0;
                for (int k = 0; k < cur_m; k++) begin
                    sy  += smp[pix][k];
                    sky += longint'(k) * smp[pix][k];
                end
                s1 = longint'(cur_m) * (cur_m - 1) / 2;
                dn = longint'(cur_m) * cur_m * (longint'(cur_m) * cur_m - 1) / 12;
                nm = (longint'(cur_m) * sky - s1 * sy) * (64'sd1 << FRAC);
                e.val = nm / dn;
            end
        end
        return e;
    endfunction

    task automatic put(input int pix, input int val, input bit first, input bit last, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_pixel  = 2'(pix);
        in_sample = 12'(val);
        in_first  = first;
        in_last   = last;
        if (first) scnt[pix] = 0;
        if (scnt[pix] < cur_m) begin
            smp[pix][scnt[pix]] = val;
            scnt[pix]++;
        end
        if (last) sbq.push_back(expect_for(pix, tag));
    endtask

    task automatic drain(input string tag);
        int waited;
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        waited = 0;
        while (sbq.size() != 0 && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        check(sbq.size() == 0, tag, sbq.size(), 0);
    endtask

    task automatic configure(input bit slope, input int l2n, input int m);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_slope = slope;
        cfg_log2n = 3'(l2n);
        cfg_m     = 6'(m);
        cur_slope = slope;
        cur_l2n   = l2n;
        cur_m     = m;
    endtask

    function automatic int sample_at(input int base, input int step, input int k, input int pix);
        int v;
        v = base + step * k + ((k * 7 + pix * 3) % 5) - 2;
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    task automatic ramp(input int pix, input int base, input int step, input int ns, input string tag);
        for (int k = 0; k < ns; k++) begin
            put(pix, sample_at(base, step, k, pix), k == 0, k == ns - 1, tag);
        end
    endtask

    // Scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R9 unexpected result", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    check(int'(out_pixel) == e.pix, {e.tag, " pixel R5"}, out_pixel, e.pix);
                    check(longint'($signed(out_value)) == e.val, {e.tag, " value"},
                          longint'($signed(out_value)), e.val);
                    check(out_incomplete == e.inc, {e.tag, " incomplete flag R7"}, out_incomplete, e.inc);
                    check(out_err == e.err, {e.tag, " error flag R8"}, out_err, e.err);
                    if (e.exact)
                        check(cyc == e.when, {e.tag, " latency R9"}, cyc, e.when);
                    else
                        check(cyc > e.when, {e.tag, " slope after divide R9"}, cyc, e.when + 1);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_pixel = '0; in_sample = '0; in_first = 1'b0; in_last = 1'b0;
        cfg_slope = 1'b0; cfg_log2n = 3'd1; cfg_m = 6'd8;
        cur_slope = 1'b0; cur_l2n = 1; cur_m = 8;
        for (int p = 0; p < NPIX; p++) scnt[p] = 0;

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", out_valid, 0);

        // Group difference, N=2, M=8
        configure(1'b0, 1, 8);
        ramp(0, 100, 20, 8, "R2 rising");
        drain("R2 rising drained");
        ramp(2, 3000, -37, 8, "R2 falling");
        drain("R2 falling drained");

        // Boundary 2N == M
        configure(1'b0, 2, 8);
        ramp(1, 50, 9, 8, "R2 2N=M");
        drain("R2 2N=M drained");

        // Invalid configurations
        configure(1'b0, 3, 8);
        ramp(0, 10, 4, 8, "R8 group too large");
        drain("R8 group drained");
        configure(1'b1, 0, 1);
        ramp(3, 5, 1, 1, "R8 M below two");
        drain("R8 M drained");

        // Least-squares slope
        configure(1'b1, 0, 8);
        ramp(3, 200, 5, 8, "R3 rising");
        drain("R3 rising drained");
        ramp(1, 4000, -13, 8, "R3 falling");
        drain("R3 falling drained");

        // Reads of another pixel while a division is running
        ramp(3, 300, 11, 8, "R10 first ramp");
        for (int k = 0; k < 7; k++) put(0, sample_at(20, 40, k, 0), k == 0, 1'b0, "R10");
        drain("R10 division done");
        put(0, sample_at(20, 40, 7, 0), 1'b0, 1'b1, "R10 ramp fed during division");
        drain("R10 drained");

        // Restart in mid-ramp
        for (int k = 0; k < 3; k++) put(1, 4000, k == 0, 1'b0, "R4");
        ramp(1, 10, 3, 8, "R4 restart");
        drain("R4 drained");

        // Largest M
        configure(1'b1, 0, 32);
        ramp(2, 0, 120, 32, "R3 max M");
        drain("R3 max M drained");

        // Interleaved pixels, consecutive ends
        configure(1'b0, 1, 6);
        for (int k = 0; k < 6; k++)
            for (int p = 0; p < NPIX; p++)
                put(p, sample_at(100 * p, 15 + p, k, p), k == 0, k == 5, "R5 interleave");
        drain("R5 drained");

        // Surplus reads are ignored
        configure(1'b0, 1, 8);
        for (int k = 0; k < 11; k++)
            put(0, (k < 8) ? sample_at(60, 25, k, 0) : 4095, k == 0, k == 10, "R6 surplus");
        drain("R6 drained");

        // Short ramps
        ramp(3, 400, 7, 3, "R7 short group");
        drain("R7 group drained");
        configure(1'b1, 0, 8);
        ramp(2, 100, 10, 5, "R7 short slope");
        drain("R7 slope drained");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule